// File: doc/BRIEF.md
# Cascadable Serial-Load Channel Enable Core

This block is the digital heart of a multi-channel LED sink driver. A serial bit stream is clocked into a shift register one bit per rising edge, and the oldest bit leaves on a serial output pin so that any number of these cores can be strung end to end. A bank of level-sensitive latches holds the pattern that drives the channels. While the load strobe is high the latches follow the register; when it falls they freeze. An active-low enable and two fault flags then gate the latched pattern onto the channel enables. The gating is purely combinational.

The two fault flags act differently. A supply-low flag clears the register and the latches asynchronously. Its release reaches the storage through a small synchroniser, so the first edges after recovery do not shift. A temperature flag only blanks the channels. The register and latches keep loading and keep their data, and the channels come back with the stored pattern once the flag drops. The serial port is a bare shift clock with no handshake. A bit is taken on every rising edge and there is no back-pressure: the sender alone sets the pace.

Top module: `sink_chain_core`

## Requirements
- R1: On each rising `clk` edge, with storage not held clear, `sdi` enters stage 0 and every stage moves up by one position toward stage CHANNELS-1.
- R2: `sdo` shows stage CHANNELS-1. A bit shifted in appears on `sdo` after CHANNELS rising edges, so a word sent most significant bit first leaves that bit on `sdo`.
- R3: While `le` is high, each latch follows its shift stage continuously, including across shifts made while `le` stays high.
- R4: While `le` is low, the latches hold their value whatever the register does.
- R5: While `oe_n` is high, every bit of `chan_on` is 0.
- R6: With `oe_n`, `uv_fault` and `ot_fault` all low, `chan_on[i]` equals latch i.
- R7: The level of `oe_n` never alters the latch contents. Outputs return unchanged after `oe_n` has been high.
- R8: While `uv_fault` is high, `chan_on` is 0 at once, without waiting for an edge, and every register and latch bit is cleared.
- R9: After `uv_fault` falls, the first two rising edges do not shift and the third one does.
- R10: While `ot_fault` is high, `chan_on` is 0, but the register and latches keep loading. When the flag clears, the channels show the latched data.
- R11: Two cores chained `sdo` to `sdi` act as one 2*CHANNELS-bit register. After 32 edges of a word sent most significant bit first, the far core holds bits 31..16 and the near core holds bits 15..0, each with bit 0 on channel 0.
- R12: `chan_on` follows `oe_n`, the fault flags and the latches with no clock delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift clock; rising edge shifts |
| uv_fault | input | 1 | Supply-low flag, active high; asynchronous clear of all storage and acts as power-on reset |
| ot_fault | input | 1 | Over-temperature flag, active high; blanks the channels only |
| sdi | input | 1 | Serial data in |
| le | input | 1 | Latch strobe; latches are transparent while high |
| oe_n | input | 1 | Output enable, active low |
| sdo | output | 1 | Serial data out (last shift stage) |
| chan_on | output | CHANNELS | Channel on/off enables |

## Verification
Two pairs of functions can fall in the same cycle. The first pair is a shift edge while the latch strobe is high. In that case the register update must flow through the transparent latches to `chan_on` within the same cycle. The bench provokes this by holding `le` high across several edges and comparing `chan_on` after each edge against an independent shift model. The second pair is an over-temperature blank during a load. Here `ot_fault` stays high while a new word is shifted and strobed in. The bench judges it by requiring zeros throughout, then the new word at once when the flag drops.

// File: rtl/scc_pkg.sv
package scc_pkg;
  localparam int unsigned SCC_CHANNELS    = 16;
  localparam int unsigned SCC_SYNC_STAGES = 2;

  function automatic logic all_clear(input logic oe_n, input logic uv, input logic ot);
    return ~oe_n & ~uv & ~ot;
  endfunction
endpackage

// File: rtl/scc_rst_sync.sv
module scc_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic async_set,
  output logic clr_out
);
  localparam int unsigned TOP = STAGES - 1;

  logic [TOP:0] chain_q;

  // Asserts at once, releases after STAGES rising edges
  always_ff @(posedge clk or posedge async_set) begin
    if (async_set) chain_q <= '1;
    else           chain_q <= {chain_q[TOP-1:0], 1'b0};
  end

  assign clr_out = chain_q[TOP];
endmodule

// File: rtl/scc_shift.sv
module scc_shift #(
  parameter int unsigned WIDTH = 16
) (
  input  logic             clk,
  input  logic             clr,
  input  logic             din,
  output logic [WIDTH-1:0] stages,
  output logic             dout
);
  localparam int unsigned MSB = WIDTH - 1;

  logic [MSB:0] stage_q;

  always_ff @(posedge clk or posedge clr) begin
    if (clr) stage_q <= '0;
    else     stage_q <= {stage_q[MSB-1:0], din};
  end

  assign stages = stage_q;
  assign dout   = stage_q[MSB];
endmodule

// File: rtl/scc_latch_bank.sv
module scc_latch_bank #(
  parameter int unsigned WIDTH = 16
) (
  input  logic             clr,
  input  logic             open,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic held;
    always_latch begin
      if (clr)       held = 1'b0;
      else if (open) held = d[i];
    end
    assign q[i] = held;
  end
endmodule

// File: rtl/scc_gate.sv
module scc_gate #(
  parameter int unsigned WIDTH = 16
) (
  input  logic [WIDTH-1:0] pattern,
  input  logic             oe_n,
  input  logic             uv,
  input  logic             ot,
  output logic [WIDTH-1:0] drive
);
  import scc_pkg::*;

  logic pass;
  assign pass = all_clear(oe_n, uv, ot);

  for (genvar i = 0; i < WIDTH; i++) begin : g_ch
    assign drive[i] = pattern[i] & pass;
  end
endmodule

// File: rtl/sink_chain_core.sv
module sink_chain_core #(
  parameter int unsigned CHANNELS    = scc_pkg::SCC_CHANNELS,
  parameter int unsigned SYNC_STAGES = scc_pkg::SCC_SYNC_STAGES
) (
  input  logic                clk,
  input  logic                uv_fault,
  input  logic                ot_fault,
  input  logic                sdi,
  input  logic                le,
  input  logic                oe_n,
  output logic                sdo,
  output logic [CHANNELS-1:0] chan_on
);
  logic                store_clr;
  logic [CHANNELS-1:0] shift_word;
  logic [CHANNELS-1:0] latch_word;

  scc_rst_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .async_set (uv_fault),
    .clr_out   (store_clr)
  );

  scc_shift #(.WIDTH(CHANNELS)) u_shift (
    .clk    (clk),
    .clr    (store_clr),
    .din    (sdi),
    .stages (shift_word),
    .dout   (sdo)
  );

  scc_latch_bank #(.WIDTH(CHANNELS)) u_latch (
    .clr  (store_clr),
    .open (le),
    .d    (shift_word),
    .q    (latch_word)
  );

  scc_gate #(.WIDTH(CHANNELS)) u_gate (
    .pattern (latch_word),
    .oe_n    (oe_n),
    .uv      (uv_fault),
    .ot      (ot_fault),
    .drive   (chan_on)
  );
endmodule

// File: rtl/scc_chk.sv
module scc_chk #(
  parameter int unsigned W = 16
) (
  input logic         clk,
  input logic         uv_fault,
  input logic         ot_fault,
  input logic         sdi,
  input logic         le,
  input logic         oe_n,
  input logic         sdo,
  input logic [W-1:0] chan_on,
  input logic         store_clr
);
  // R8
  uv_blank_chk: assert property (@(posedge clk) uv_fault |-> chan_on == '0);

  // R5
  oe_off_chk: assert property (@(posedge clk) disable iff (uv_fault)
    oe_n |-> chan_on == '0);

  // R10
  ot_blank_chk: assert property (@(posedge clk) disable iff (uv_fault)
    ot_fault |-> chan_on == '0);

  // R1
  shift_in_chk: assert property (@(posedge clk) disable iff (uv_fault || store_clr)
    (le && !oe_n && !ot_fault && $past(!store_clr) && $past(!uv_fault))
      |-> chan_on[0] == $past(sdi));

  // R2
  sdo_stage_chk: assert property (@(posedge clk) disable iff (uv_fault || store_clr)
    (le && !oe_n && !ot_fault && $past(le && !oe_n && !ot_fault)
      && $past(!store_clr) && $past(!uv_fault))
      |-> sdo == $past(chan_on[W-2]));
endmodule

bind sink_chain_core scc_chk #(.W(CHANNELS)) u_chk (
  .clk       (clk),
  .uv_fault  (uv_fault),
  .ot_fault  (ot_fault),
  .sdi       (sdi),
  .le        (le),
  .oe_n      (oe_n),
  .sdo       (sdo),
  .chan_on   (chan_on),
  .store_clr (store_clr)
);

// File: tb/sim_sink_chain_core.sv
module sim_sink_chain_core;
  logic clk = 1'b0;
  logic uv_fault = 1'b1;
  logic ot_fault = 1'b0;
  logic sdi = 1'b0;
  logic le = 1'b0;
  logic oe_n = 1'b1;
  logic sdo0, sdo1;
  logic [15:0] chan0, chan1;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  sink_chain_core u0 (.clk(clk), .uv_fault(uv_fault), .ot_fault(ot_fault), .sdi(sdi),
                      .le(le), .oe_n(oe_n), .sdo(sdo0), .chan_on(chan0));
  sink_chain_core u1 (.clk(clk), .uv_fault(uv_fault), .ot_fault(ot_fault), .sdi(sdo0),
                      .le(le), .oe_n(oe_n), .sdo(sdo1), .chan_on(chan1));

  // word, oe_n, ot_fault, expected chan_on
  localparam logic [33:0] VEC [6] = '{
    {16'hA5C3, 1'b0, 1'b0, 16'hA5C3},
    {16'hFFFF, 1'b0, 1'b0, 16'hFFFF},
    {16'h0001, 1'b0, 1'b0, 16'h0001},
    {16'h8000, 1'b1, 1'b0, 16'h0000},
    {16'h5A5A, 1'b0, 1'b1, 16'h0000},
    {16'h0000, 1'b0, 1'b0, 16'h0000}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic shift_bit(input logic b);
    sdi = b;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic shift_word16(input logic [15:0] w);
    for (int i = 15; i >= 0; i--) shift_bit(w[i]);
  endtask

  task automatic strobe();
    le = 1'b1; #2; le = 1'b0; #1;
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [15:0] model;
    @(negedge clk);
    // Reset state under the supply-low flag (R8)
    chk("R8 reset chan", {16'h0, chan0}, 32'h0);
    @(negedge clk); @(negedge clk);
    uv_fault = 1'b0;
    repeat (3) @(negedge clk);
    oe_n = 1'b0;
    #1;
    chk("R8 after power-on chan", {16'h0, chan0}, 32'h0);
    chk("R2 after power-on sdo", {31'h0, sdo0}, 32'h0);

    // Table walk (R1 R2 R5 R6 R10 R12)
    for (int v = 0; v < 6; v++) begin
      shift_word16(VEC[v][33:18]);
      chk("R2 sdo after load", {31'h0, sdo0}, {31'h0, VEC[v][33]});
      strobe();
      oe_n = VEC[v][17];
      ot_fault = VEC[v][16];
      #1;
      // R12: no clock edge between the control change and this sample
      chk("R6 R5 R10 R12 table", {16'h0, chan0}, {16'h0, VEC[v][15:0]});
      oe_n = 1'b0;
      ot_fault = 1'b0;
      #1;
    end

    // R4: latches hold while le is low
    shift_word16(16'h1234);
    strobe();
    chk("R6 load 1234", {16'h0, chan0}, 32'h1234);
    shift_word16(16'hEDCB);
    chk("R4 hold while le low", {16'h0, chan0}, 32'h1234);

    // R7: oe_n high then low, data unchanged
    oe_n = 1'b1; #1;
    chk("R5 oe_n high", {16'h0, chan0}, 32'h0);
    oe_n = 1'b0; #1;
    chk("R7 data kept after oe_n", {16'h0, chan0}, 32'h1234);

    // R3: transparent latches follow each shift
    le = 1'b1; #1;
    model = 16'hEDCB;
    chk("R3 transparent on open", {16'h0, chan0}, {16'h0, model});
    for (int i = 0; i < 5; i++) begin
      shift_bit(i[0]);
      model = {model[14:0], i[0]};
      chk("R3 R1 follow shift", {16'h0, chan0}, {16'h0, model});
    end
    le = 1'b0;

    // R10: load during over-temperature
    ot_fault = 1'b1;
    shift_word16(16'h00FF);
    strobe();
    chk("R10 blank during load", {16'h0, chan0}, 32'h0);
    ot_fault = 1'b0; #1;
    chk("R10 resume with new data", {16'h0, chan0}, 32'h00FF);

    // R8 R9: async clear and synchronised release
    shift_word16(16'hFFFF);
    strobe();
    #3;
    uv_fault = 1'b1; #1;
    chk("R8 immediate blank", {16'h0, chan0}, 32'h0);
    @(negedge clk);
    uv_fault = 1'b0; #1;
    chk("R8 latches cleared", {16'h0, chan0}, 32'h0);
    chk("R8 register cleared sdo", {31'h0, sdo0}, 32'h0);
    le = 1'b1;
    shift_bit(1'b1);
    chk("R9 first edge ignored", {16'h0, chan0}, 32'h0);
    shift_bit(1'b1);
    chk("R9 second edge ignored", {16'h0, chan0}, 32'h0);
    shift_bit(1'b1);
    chk("R9 third edge shifts", {16'h0, chan0}, 32'h0001);
    le = 1'b0;

    // R11: two cores chained as a 32-bit register
    for (int i = 31; i >= 0; i--) shift_bit(logic'(32'hDEADBEEF >> i));
    strobe();
    chk("R11 near core", {16'h0, chan0}, 32'hBEEF);
    chk("R11 far core", {16'h0, chan1}, 32'hDEAD);
    chk("R11 far sdo", {31'h0, sdo1}, 32'h1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule